// File: doc/BRIEF.md
# AC'97 Link Reset and Powerdown Sequencer

This block sits on the codec side of an AC'97 link. It decides when the codec may drive its bit clock, when the serial input line back to the controller must be held low, and when the codec reports itself ready. It runs from a free-running reference clock, because the bit clock it controls can be stopped.

While the active-low link reset is held, the block keeps the link quiet: no bit clock, input data held low, codec ready cleared. A fixed time after reset is released it enables bit-clock generation. It then waits for the first rising edge of SYNC and, a second fixed time later, raises codec ready. When the register block reports that the link-powerdown bit has been written, the block waits a short delay, stops the bit clock and forces the serial input data low. In that state it measures every SYNC high pulse. A pulse at least the warm-reset minimum long starts a delayed restart of the clock, counted from the falling edge of SYNC. A shorter pulse is ignored. On a warm restart the block pulses a request to clear the powerdown bit and leaves codec ready set. A link reset at any time takes everything back to the start.

All delays are parameters in reference-clock cycles. The defaults suit a 100 MHz reference: 40 µs to clock start, 62.5 µs to ready, 0.28 µs to stop, a 1 µs warm-reset pulse and a 0.26 µs restart delay. SYNC and the link reset are asynchronous to the reference clock and pass through synchronizers of `SYNC_STAGES` flops. Every input-to-output delay below includes those flops and the output register. In the requirements, LAT means `SYNC_STAGES + 1` reference cycles.

Top module: `ac97_link_pwr_seq`

## Requirements
- R1: After the synchronous reset `rst`, the outputs are `bclk_en`=0, `sdin_force_low`=1, `codec_ready`=0 and `pdn_clear`=0.
- R2: While `link_rst_n` is low (active-low link reset), LAT cycles after it falls the block shows `bclk_en`=0, `sdin_force_low`=1 and `codec_ready`=0, and it holds those values until release.
- R3: After `link_rst_n` rises, `bclk_en` rises and `sdin_force_low` falls exactly LAT + `CLK_START_CYC` cycles later.
- R4: `codec_ready` rises exactly LAT + `READY_CYC` cycles after the first rising edge of `sync_in` that follows clock enable.
- R5: A one-cycle `pdn_req` pulse while the link is ready stops the clock exactly `PDN_DELAY_CYC` + 1 cycles later. At that point `bclk_en`=0 and `sdin_force_low`=1, and `codec_ready` stays 1.
- R6: A `pdn_req` pulse before `codec_ready` is set has no effect on `bclk_en` or `sdin_force_low`.
- R7: While powered down, a `sync_in` high pulse of W ≥ `WARM_MIN_CYC` reference cycles restarts the link exactly LAT + `RESTART_CYC` cycles after `sync_in` falls. At that point `bclk_en`=1 and `sdin_force_low`=0, and `pdn_clear` is high for exactly that one cycle.
- R8: While powered down, a `sync_in` pulse with W < `WARM_MIN_CYC` is ignored: the clock stays off and the input line stays forced low. The width of one pulse is never added to the next.
- R9: A link reset during powerdown clears `codec_ready` and leads back into the full start-up sequence of R3 and R4.
- R10: SYNC activity while the link runs normally has no effect on the outputs.
- R11: `bclk_en` is never 0 unless `sdin_force_low` is 1, and `pdn_clear` never lasts more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high block reset |
| link_rst_n | input | 1 | Active-low link reset, asynchronous |
| sync_in | input | 1 | Link SYNC, asynchronous |
| pdn_req | input | 1 | One-cycle pulse: powerdown bit written (reference-clock domain) |
| bclk_en | output | 1 | Enable for bit-clock generation |
| sdin_force_low | output | 1 | Hold serial input data low |
| codec_ready | output | 1 | Codec ready indication |
| pdn_clear | output | 1 | One-cycle pulse: clear the powerdown bit after a warm reset |

## Verification
The assertions assume that `pdn_req` is a single reference-cycle pulse already in the reference domain. They also assume that SYNC and the link reset change slowly enough for the synchronizers to pass every level cleanly. The stimulus changes all inputs on the falling reference edge. It holds every SYNC pulse for a whole number of reference cycles. It raises `pdn_req` for one cycle only, and only after the block has settled in the state under test. With those inputs, every pulse width in reference cycles can be compared directly against `WARM_MIN_CYC`. The bench sweeps the width across the whole range around that limit.

// File: rtl/ac97_pwr_pkg.sv
package ac97_pwr_pkg;

  typedef enum logic [2:0] {
    PS_COLD,       // link reset held
    PS_START,      // counting to bit clock start
    PS_WAIT_SYNC,  // clock running, waiting for first SYNC
    PS_READY_CNT,  // counting to codec ready
    PS_RUN,        // normal operation
    PS_PDN_CNT,    // powerdown accepted, clock still running
    PS_DOWN,       // clock stopped, measuring SYNC pulses
    PS_RESTART     // warm reset seen, delayed restart
  } pwr_state_t;

  function automatic logic state_clk_on(pwr_state_t s);
    return (s == PS_WAIT_SYNC) || (s == PS_READY_CNT) ||
           (s == PS_RUN) || (s == PS_PDN_CNT);
  endfunction

  function automatic logic state_ready(pwr_state_t s);
    return (s == PS_RUN) || (s == PS_PDN_CNT) ||
           (s == PS_DOWN) || (s == PS_RESTART);
  endfunction

endpackage

// File: rtl/ac97_sync_bit.sv
module ac97_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain[i] <= RST_VAL;
        end else if (i == 0) begin
          chain[i] <= d;
        end else begin
          chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/ac97_span_timer.sv
module ac97_span_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [WIDTH-1:0] count
);

  localparam logic [WIDTH-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      count <= '0;
    end else if (count != TOP) begin
      count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/ac97_link_pwr_seq.sv
module ac97_link_pwr_seq
  import ac97_pwr_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int CLK_START_CYC = 4000,
  parameter int READY_CYC     = 6250,
  parameter int PDN_DELAY_CYC = 28,
  parameter int WARM_MIN_CYC  = 100,
  parameter int RESTART_CYC   = 26
) (
  input  logic clk,
  input  logic rst,
  input  logic link_rst_n,
  input  logic sync_in,
  input  logic pdn_req,
  output logic bclk_en,
  output logic sdin_force_low,
  output logic codec_ready,
  output logic pdn_clear
);

  localparam int MAX_AB  = (CLK_START_CYC > READY_CYC) ? CLK_START_CYC : READY_CYC;
  localparam int MAX_CD  = (PDN_DELAY_CYC > WARM_MIN_CYC) ? PDN_DELAY_CYC : WARM_MIN_CYC;
  localparam int MAX_ABC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int MAX_ALL = (MAX_ABC > RESTART_CYC) ? MAX_ABC : RESTART_CYC;
  localparam int CNT_W   = $clog2(MAX_ALL + 2) + 1;

  localparam logic [CNT_W-1:0] LIM_START   = CNT_W'(CLK_START_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_READY   = CNT_W'(READY_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_PDN     = CNT_W'(PDN_DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_WARM    = CNT_W'(WARM_MIN_CYC);
  localparam logic [CNT_W-1:0] LIM_RESTART = CNT_W'(RESTART_CYC - 1);

  logic             rst_n_s;
  logic             sync_s;
  logic             sync_q;
  logic             cnt_clr;
  logic [CNT_W-1:0] cnt;
  pwr_state_t       state_q;
  pwr_state_t       state_d;

  ac97_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk (clk),
    .rst (rst),
    .d   (link_rst_n),
    .q   (rst_n_s)
  );

  ac97_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_frame_sync (
    .clk (clk),
    .rst (rst),
    .d   (sync_in),
    .q   (sync_s)
  );

  ac97_span_timer #(.WIDTH(CNT_W)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .count (cnt)
  );

  always_comb begin
    state_d = state_q;
    if (!rst_n_s) begin
      state_d = PS_COLD;
    end else begin
      unique case (state_q)
        PS_COLD:      state_d = PS_START;
        PS_START:     if (cnt >= LIM_START) state_d = PS_WAIT_SYNC;
        PS_WAIT_SYNC: if (sync_s && !sync_q) state_d = PS_READY_CNT;
        PS_READY_CNT: if (cnt >= LIM_READY) state_d = PS_RUN;
        PS_RUN:       if (pdn_req) state_d = PS_PDN_CNT;
        PS_PDN_CNT:   if (cnt >= LIM_PDN) state_d = PS_DOWN;
        PS_DOWN:      if (!sync_s && sync_q && (cnt >= LIM_WARM)) state_d = PS_RESTART;
        PS_RESTART:   if (cnt >= LIM_RESTART) state_d = PS_RUN;
        default:      state_d = PS_COLD;
      endcase
    end
  end

  // Timer restarts on every state change; while powered down it measures
  // only the current SYNC high pulse.
  assign cnt_clr = (state_d != state_q) || ((state_q == PS_DOWN) && !sync_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= PS_COLD;
      sync_q         <= 1'b0;
      bclk_en        <= 1'b0;
      sdin_force_low <= 1'b1;
      codec_ready    <= 1'b0;
      pdn_clear      <= 1'b0;
    end else begin
      state_q        <= state_d;
      sync_q         <= sync_s;
      bclk_en        <= state_clk_on(state_d);
      sdin_force_low <= !state_clk_on(state_d);
      codec_ready    <= state_ready(state_d);
      pdn_clear      <= (state_q == PS_RESTART) && (state_d == PS_RUN);
    end
  end

endmodule

// File: rtl/ac97_link_pwr_seq_chk.sv
module ac97_link_pwr_seq_chk (
  input logic clk,
  input logic rst,
  input logic link_rst_n,
  input logic bclk_en,
  input logic sdin_force_low,
  input logic codec_ready,
  input logic pdn_clear
);

  logic [1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || link_rst_n) begin
      low_run <= '0;
    end else if (low_run != 2'd3) begin
      low_run <= low_run + 2'd1;
    end
  end

  AST_COLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    (low_run == 2'd3) |-> (!codec_ready && !bclk_en && sdin_force_low)); // R2

  AST_READY_WITH_CLK: assert property (@(posedge clk) disable iff (rst)
    $rose(codec_ready) |-> bclk_en); // R4

  AST_WARM_CLEARS_PDN: assert property (@(posedge clk) disable iff (rst)
    ($rose(bclk_en) && codec_ready) |-> pdn_clear); // R7

  AST_CLEAR_AT_RESTART: assert property (@(posedge clk) disable iff (rst)
    pdn_clear |-> (bclk_en && !sdin_force_low && codec_ready)); // R7

  AST_QUIET_NO_CLK: assert property (@(posedge clk) disable iff (rst)
    !bclk_en |-> sdin_force_low); // R11

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    pdn_clear |=> !pdn_clear); // R11

endmodule

bind ac97_link_pwr_seq ac97_link_pwr_seq_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .link_rst_n     (link_rst_n),
  .bclk_en        (bclk_en),
  .sdin_force_low (sdin_force_low),
  .codec_ready    (codec_ready),
  .pdn_clear      (pdn_clear)
);

// File: tb/ac97_link_pwr_seq_tb_top.sv
module ac97_link_pwr_seq_tb_top;

  localparam int SS  = 2;
  localparam int CS  = 20;
  localparam int RC  = 30;
  localparam int PD  = 5;
  localparam int WM  = 10;
  localparam int RS  = 6;
  localparam int LAT = SS + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic link_rst_n = 1'b0;
  logic sync_in = 1'b0;
  logic pdn_req = 1'b0;
  logic bclk_en, sdin_force_low, codec_ready, pdn_clear;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ac97_link_pwr_seq #(
    .SYNC_STAGES(SS), .CLK_START_CYC(CS), .READY_CYC(RC),
    .PDN_DELAY_CYC(PD), .WARM_MIN_CYC(WM), .RESTART_CYC(RS)
  ) dut_i (
    .clk(clk), .rst(rst), .link_rst_n(link_rst_n), .sync_in(sync_in),
    .pdn_req(pdn_req), .bclk_en(bclk_en), .sdin_force_low(sdin_force_low),
    .codec_ready(codec_ready), .pdn_clear(pdn_clear)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic e_clk,
                            input logic e_low, input logic e_rdy, input logic e_clr);
    check(req, "bclk_en", bclk_en, e_clk);
    check(req, "sdin_force_low", sdin_force_low, e_low);
    check(req, "codec_ready", codec_ready, e_rdy);
    check(req, "pdn_clear", pdn_clear, e_clr);
  endtask

  // R3, R4, R6, R10: full start-up from a released link reset
  task automatic startup();
    link_rst_n = 1'b1;
    step(LAT + CS - 1);
    check_outs("R3", 1'b0, 1'b1, 1'b0, 1'b0);
    step(1);
    check_outs("R3", 1'b1, 1'b0, 1'b0, 1'b0);
    // R6: powerdown request before ready is ignored
    pdn_req = 1'b1;
    step(1);
    pdn_req = 1'b0;
    step(PD + 4);
    check_outs("R6", 1'b1, 1'b0, 1'b0, 1'b0);
    // R4: first SYNC rising edge starts the ready count
    sync_in = 1'b1;
    step(LAT + RC - 1);
    check("R4", "codec_ready early", codec_ready, 1'b0);
    step(1);
    check_outs("R4", 1'b1, 1'b0, 1'b1, 1'b0);
    sync_in = 1'b0;
    // R10: frame SYNC pulses while running change nothing
    for (int f = 0; f < 3; f++) begin
      step(4);
      sync_in = 1'b1;
      step(16);
      sync_in = 1'b0;
    end
    step(LAT + 2);
    check_outs("R10", 1'b1, 1'b0, 1'b1, 1'b0);
  endtask

  // R5: powerdown from the running state
  task automatic power_down();
    pdn_req = 1'b1;
    step(1);
    pdn_req = 1'b0;
    step(PD - 1);
    check("R5", "bclk_en before stop", bclk_en, 1'b1);
    step(1);
    check_outs("R5", 1'b0, 1'b1, 1'b1, 1'b0);
  endtask

  // R7, R8: one SYNC pulse of w cycles while powered down
  task automatic warm_pulse(input int w);
    sync_in = 1'b1;
    step(w);
    sync_in = 1'b0;
    if (w >= WM) begin
      step(LAT + RS - 1);
      check("R7", $sformatf("still off w=%0d", w), bclk_en, 1'b0);
      step(1);
      check_outs("R7", 1'b1, 1'b0, 1'b1, 1'b1);
      step(1);
      check("R7", "pdn_clear single cycle", pdn_clear, 1'b0);
    end else begin
      step(LAT + RS + 4);
      check_outs("R8", 1'b0, 1'b1, 1'b1, 1'b0);
    end
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    step(3);
    check_outs("R1", 1'b0, 1'b1, 1'b0, 1'b0);
    rst = 1'b0;
    step(LAT + 2);
    check_outs("R2", 1'b0, 1'b1, 1'b0, 1'b0);

    startup();

    // Sweep SYNC widths around the warm-reset limit
    for (int w = 1; w <= WM + 3; w++) begin
      power_down();
      warm_pulse(w);
      if (w < WM) begin
        // R8: widths do not accumulate; a second short pulse also fails
        warm_pulse(WM - 1);
        warm_pulse(WM);
      end
    end

    // R9: link reset while powered down
    power_down();
    link_rst_n = 1'b0;
    step(LAT - 1);
    check("R9", "codec_ready before cold takes effect", codec_ready, 1'b1);
    step(1);
    check_outs("R9", 1'b0, 1'b1, 1'b0, 1'b0);
    step(20);
    check_outs("R2", 1'b0, 1'b1, 1'b0, 1'b0);
    startup();
    power_down();
    warm_pulse(WM + 5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule